// File: doc/BRIEF.md
# Serial Flash Write-Protection Controller

This block is the guard that sits beside the instruction decoder of a serial NOR flash. The decoder hands it every finished instruction at the moment chip select is released: the opcode, the byte address, the status byte to be written, and how many serial clocks the select window held. One cycle later the guard answers with a single accept or reject pulse. The array and the timing engines act only on accepted instructions.

The guard holds the write-enable latch, the three block-protect bits and the status-register lock bit. It samples the write-protect pin and returns the status byte that a read-status instruction would shift out. A small state machine follows power: `PW_WAIT` counts a settling delay after reset, `PW_ACTIVE` is normal operation and `PW_SLEEP` is deep power-down. It has three transitions. `T_SETTLE` goes from `PW_WAIT` to `PW_ACTIVE` when the delay expires. `T_DOZE` goes from `PW_ACTIVE` to `PW_SLEEP` on an accepted power-down instruction. `T_WAKE` goes from `PW_SLEEP` to `PW_ACTIVE` on an accepted release instruction.

Opcodes: set-latch 0x06, clear-latch 0x04, status write 0x01, page program 0x02, sector erase 0xD8, bulk erase 0xC7, power-down 0xB9, release 0xAB.

Top module: `flash_write_guard`

## Requirements
- R1: On reset, `status` reads 0 apart from bit 0, and both verdict outputs are low. Every instruction is rejected until `PUW_CYCLES` clock edges after reset release. An instruction sampled at edge `PUW_CYCLES+1` or later is judged normally.
- R2: Each cycle with `cmd_valid` high produces exactly one of `cmd_accept` or `cmd_reject` in the following cycle. Neither pulses in any other cycle.
- R3: In the active state, 0x06 and 0x04 are accepted whatever the clock count. 0x06 sets the latch (status bit 1) and 0x04 clears it.
- R4: Opcodes 0x01, 0x02, 0xD8 and 0xC7 are rejected while the latch is clear.
- R5: Opcodes 0x01, 0x02, 0xD8 and 0xC7 are rejected when the clock count is not a multiple of eight.
- R6: Page program and sector erase are rejected when the target sector, given by `cmd_addr[18:16]`, is protected. The latch is left unchanged. Protection by BP code: 0 protects nothing, 1 protects sector 7, 2 protects sectors 6–7, 3 protects sectors 4–7, and 4 to 7 protect all sectors.
- R7: Bulk erase is accepted only when all three BP bits are zero.
- R8: An accepted status write loads the lock bit from `cmd_data[7]` and BP from `cmd_data[4:2]`. While `wp_n` is low and the lock bit is set, a status write is rejected and the status bits keep their values.
- R9: An `op_done` pulse clears the latch. If a latch-changing instruction arrives in the same cycle, the instruction's effect wins.
- R10: An accepted 0xB9 enters deep power-down. There, every opcode except 0xAB is rejected and leaves the status unchanged. 0xAB is accepted and returns the block to the active state.
- R11: `status` is {lock, 0, 0, BP2, BP1, BP0, latch, busy}, with bit 0 following `busy_in` in the same cycle.
- R12: In the active state, any opcode outside the eight listed is rejected. 0xAB outside deep power-down is accepted and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| cmd_valid | input | 1 | One-cycle strobe: an instruction ended at chip-select release |
| cmd_opcode | input | 8 | Decoded opcode |
| cmd_addr | input | 19 | Target byte address |
| cmd_data | input | 8 | Status byte carried by a status write |
| cmd_clk_count | input | 16 | Serial clocks counted inside the select window |
| op_done | input | 1 | Completion strobe of a status write, program or erase |
| wp_n | input | 1 | Write-protect pin, active low |
| busy_in | input | 1 | Write-in-progress flag from the timing engine |
| cmd_accept | output | 1 | Instruction accepted (one cycle after `cmd_valid`) |
| cmd_reject | output | 1 | Instruction rejected (one cycle after `cmd_valid`) |
| status | output | 8 | Visible status byte |

## Verification
The verdict and every status bit except bit 0 are registered at the clock edge that samples `cmd_valid`. The bench drives inputs on falling edges, lets exactly one rising edge pass and reads both results at the next falling edge. It samples the idle cycle after each verdict to confirm the pulse lasts one cycle. Status bit 0 has no register, so it is read in the same half cycle that `busy_in` changes. The settling boundary is checked at the edge before the state change and at the edge that follows it.

// File: rtl/fwg_pkg.sv
package fwg_pkg;

    typedef enum logic [1:0] {
        PW_WAIT,
        PW_ACTIVE,
        PW_SLEEP
    } pwr_state_t;

    localparam logic [7:0] OP_LATCH_SET = 8'h06;
    localparam logic [7:0] OP_LATCH_CLR = 8'h04;
    localparam logic [7:0] OP_SR_WRITE  = 8'h01;
    localparam logic [7:0] OP_PROGRAM   = 8'h02;
    localparam logic [7:0] OP_SECT_ERS  = 8'hD8;
    localparam logic [7:0] OP_BULK_ERS  = 8'hC7;
    localparam logic [7:0] OP_DOZE      = 8'hB9;
    localparam logic [7:0] OP_WAKE      = 8'hAB;

    typedef struct packed {
        logic accept;
        logic set_latch;
        logic clr_latch;
        logic load_sr;
        logic go_sleep;
        logic wake;
    } verdict_t;

endpackage

// File: rtl/fwg_power_fsm.sv
module fwg_power_fsm
    import fwg_pkg::*;
#(
    parameter int PUW_CYCLES = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_sleep,
    input  logic       wake,
    output pwr_state_t state
);
    localparam int CW = (PUW_CYCLES < 2) ? 1 : $clog2(PUW_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(PUW_CYCLES - 1);

    pwr_state_t   nxt;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PW_WAIT;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (state == PW_WAIT) cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            PW_WAIT:   if (cnt == LAST) nxt = PW_ACTIVE;   // T_SETTLE
            PW_ACTIVE: if (go_sleep)    nxt = PW_SLEEP;    // T_DOZE
            PW_SLEEP:  if (wake)        nxt = PW_ACTIVE;   // T_WAKE
            default:                    nxt = PW_WAIT;
        endcase
    end

    // R1: the settling state is left only towards normal operation
    p_settle_to_active_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == PW_WAIT && state != PW_WAIT) |-> state == PW_ACTIVE);

    // R10: sleep is entered only on a power-down request
    p_sleep_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == PW_SLEEP) |-> $past(go_sleep));

endmodule

// File: rtl/fwg_protect_map.sv
module fwg_protect_map #(
    parameter int SECTOR_W = 3
) (
    input  logic [2:0]          bp,
    input  logic [SECTOR_W-1:0] sector,
    output logic                locked
);
    localparam int NSECT = 1 << SECTOR_W;

    always_comb begin
        if (bp == 3'd0)
            locked = 1'b0;
        else if (bp[2])
            locked = 1'b1;
        else
            locked = int'(sector) >= NSECT - (1 << (int'(bp) - 1));
    end

endmodule

// File: rtl/fwg_cmd_judge.sv
module fwg_cmd_judge
    import fwg_pkg::*;
(
    input  pwr_state_t state,
    input  logic [7:0] opcode,
    input  logic       count_ok,
    input  logic       latch,
    input  logic [2:0] bp,
    input  logic       sr_lock,
    input  logic       wp_n,
    input  logic       sector_locked,
    output verdict_t   v
);
    logic mod_ok;
    assign mod_ok = latch && count_ok;

    always_comb begin
        v = '0;
        unique case (state)
            PW_WAIT: v = '0;
            PW_SLEEP: begin
                if (opcode == OP_WAKE) begin
                    v.accept = 1'b1;
                    v.wake   = 1'b1;
                end
            end
            PW_ACTIVE: begin
                case (opcode)
                    OP_LATCH_SET: begin v.accept = 1'b1; v.set_latch = 1'b1; end
                    OP_LATCH_CLR: begin v.accept = 1'b1; v.clr_latch = 1'b1; end
                    OP_DOZE:      begin v.accept = 1'b1; v.go_sleep  = 1'b1; end
                    OP_WAKE:      v.accept = 1'b1;
                    OP_SR_WRITE: begin
                        v.accept  = mod_ok && !(sr_lock && !wp_n);
                        v.load_sr = v.accept;
                    end
                    OP_PROGRAM, OP_SECT_ERS: v.accept = mod_ok && !sector_locked;
                    OP_BULK_ERS:             v.accept = mod_ok && (bp == 3'd0);
                    default:                 v.accept = 1'b0;
                endcase
            end
            default: v = '0;
        endcase
    end

endmodule

// File: rtl/flash_write_guard.sv
module flash_write_guard
    import fwg_pkg::*;
#(
    parameter int ADDR_W     = 19,
    parameter int SECTOR_W   = 3,
    parameter int CNT_W      = 16,
    parameter int PUW_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_opcode,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    input  logic [CNT_W-1:0]  cmd_clk_count,
    input  logic              op_done,
    input  logic              wp_n,
    input  logic              busy_in,
    output logic              cmd_accept,
    output logic              cmd_reject,
    output logic [7:0]        status
);
    pwr_state_t          pstate;
    verdict_t            v;
    logic                latch;
    logic [2:0]          bp;
    logic                sr_lock;
    logic                sector_locked;
    logic [SECTOR_W-1:0] sector;
    logic                count_ok;
    logic                unused_bits;

    assign sector      = cmd_addr[ADDR_W-1 -: SECTOR_W];
    assign count_ok    = (cmd_clk_count[2:0] == 3'd0);
    assign unused_bits = ^{cmd_addr[ADDR_W-SECTOR_W-1:0], cmd_clk_count[CNT_W-1:3],
                           cmd_data[6:5], cmd_data[1:0]};

    fwg_power_fsm #(.PUW_CYCLES(PUW_CYCLES)) u_power (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_sleep (cmd_valid && v.go_sleep),
        .wake     (cmd_valid && v.wake),
        .state    (pstate)
    );

    fwg_protect_map #(.SECTOR_W(SECTOR_W)) u_map (
        .bp     (bp),
        .sector (sector),
        .locked (sector_locked)
    );

    fwg_cmd_judge u_judge (
        .state         (pstate),
        .opcode        (cmd_opcode),
        .count_ok      (count_ok),
        .latch         (latch),
        .bp            (bp),
        .sr_lock       (sr_lock),
        .wp_n          (wp_n),
        .sector_locked (sector_locked),
        .v             (v)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_accept <= 1'b0;
            cmd_reject <= 1'b0;
            latch      <= 1'b0;
            bp         <= 3'd0;
            sr_lock    <= 1'b0;
        end else begin
            cmd_accept <= cmd_valid && v.accept;
            cmd_reject <= cmd_valid && !v.accept;
            if (op_done) latch <= 1'b0;
            if (cmd_valid && v.set_latch) latch <= 1'b1;
            if (cmd_valid && v.clr_latch) latch <= 1'b0;
            if (cmd_valid && v.load_sr) begin
                sr_lock <= cmd_data[7];
                bp      <= cmd_data[4:2];
            end
        end
    end

    assign status = {sr_lock, 2'b00, bp, latch, busy_in};

    // R2: exactly one verdict per instruction
    p_one_verdict_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> (cmd_accept ^ cmd_reject));

    // R2: no verdict without an instruction
    p_no_stray_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !(cmd_accept || cmd_reject));

    // R4: modifying instructions need the latch
    p_latch_needed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !latch && (cmd_opcode == OP_SR_WRITE || cmd_opcode == OP_PROGRAM ||
         cmd_opcode == OP_SECT_ERS || cmd_opcode == OP_BULK_ERS)) |=> cmd_reject);

    // R7: bulk erase blocked while any BP bit is set
    p_bulk_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_opcode == OP_BULK_ERS && bp != 3'd0) |=> cmd_reject);

    // R8: hardware lock holds the status bits
    p_hw_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_opcode == OP_SR_WRITE && !wp_n && sr_lock)
        |=> (cmd_reject && $stable(bp) && $stable(sr_lock)));

    // R10: in deep power-down only release is honoured
    p_sleep_guard_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && pstate == PW_SLEEP && cmd_opcode != OP_WAKE) |=> cmd_reject);

endmodule

// File: tb/test_flash_write_guard.sv
module test_flash_write_guard;
    localparam int PUW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_opcode = '0;
    logic [18:0] cmd_addr = '0;
    logic [7:0]  cmd_data = '0;
    logic [15:0] cmd_clk_count = '0;
    logic        op_done = 1'b0;
    logic        wp_n = 1'b1;
    logic        busy_in = 1'b0;
    logic        cmd_accept, cmd_reject;
    logic [7:0]  status;

    int checks = 0;
    int fails  = 0;
    logic got_acc, got_rej;

    always #4 clk = ~clk;

    flash_write_guard #(.PUW_CYCLES(PUW)) i_flash_write_guard (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_clk_count(cmd_clk_count),
        .op_done(op_done), .wp_n(wp_n), .busy_in(busy_in),
        .cmd_accept(cmd_accept), .cmd_reject(cmd_reject), .status(status)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one instruction; verdict read at the falling edge after the sampling edge
    task automatic send(input logic [7:0] op, input logic [18:0] a,
                        input logic [15:0] n, input logic [7:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_opcode = op; cmd_addr = a; cmd_clk_count = n; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        got_acc = cmd_accept;
        got_rej = cmd_reject;
    endtask

    task automatic pulse_done();
        @(negedge clk); op_done = 1'b1;
        @(negedge clk); op_done = 1'b0;
    endtask

    task automatic expect_verdict(input bit acc, input string req);
        check(got_acc == acc && got_rej == !acc, req, {got_acc, got_rej}, {acc, !acc});
    endtask

    // set BP and lock through the normal path, finishing with the latch clear
    task automatic load_sr(input logic lk, input logic [2:0] b);
        send(8'h06, '0, 16'd8, '0);
        send(8'h01, '0, 16'd16, {lk, 2'b00, b, 2'b00});
        pulse_done();
    endtask

    function automatic bit sect_prot(input int b, input int s);
        int n;
        if (b == 0) n = 0;
        else if (b >= 4) n = 8;
        else n = 1 << (b - 1);
        return s >= 8 - n;
    endfunction

    initial begin
        #(8 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(status == 8'h00 && !cmd_accept && !cmd_reject, "R1 reset", status, 0);
        rst_n = 1'b1;                        // released at a falling edge
        repeat (PUW - 1) @(posedge clk);
        send(8'h06, '0, 16'd8, '0);          // sampled at edge PUW
        expect_verdict(1'b0, "R1 settle edge");
        check(status[1] == 1'b0, "R1 latch stays clear", status, 0);
        send(8'h06, '0, 16'd8, '0);          // sampled at edge PUW+1
        expect_verdict(1'b1, "R1 first accepted");
        check(status[1] == 1'b1, "R3 latch set", status[1], 1);
        @(negedge clk);
        check(!cmd_accept && !cmd_reject, "R2 single pulse", {cmd_accept, cmd_reject}, 0);
        send(8'h04, '0, 16'd5, '0);
        expect_verdict(1'b1, "R3 clear any count");
        check(status[1] == 1'b0, "R3 latch cleared", status[1], 0);

        // R11: busy bit passes straight through
        @(negedge clk); busy_in = 1'b1; #1;
        check(status[0] == 1'b1, "R11 busy bit", status[0], 1);
        busy_in = 1'b0; #1;
        check(status[0] == 1'b0, "R11 busy clear", status[0], 0);

        // R12 / R4: sweep all opcodes with the latch clear
        for (int op = 0; op < 256; op++) begin
            bit exp_acc;
            exp_acc = (op == 8'h06 || op == 8'h04 || op == 8'hB9 || op == 8'hAB);
            send(op[7:0], '0, 16'd8, 8'h9C);
            expect_verdict(exp_acc, "R12/R4 opcode sweep");
            if (op == 8'h06) send(8'h04, '0, 16'd8, '0);
            if (op == 8'hB9) send(8'hAB, '0, 16'd8, '0);
        end
        check(status == 8'h00, "R4 state unchanged", status, 0);

        // R5: clock count sweep on page program
        for (int n = 0; n < 41; n++) begin
            send(8'h06, '0, 16'd8, '0);
            send(8'h02, '0, n[15:0], '0);
            expect_verdict((n % 8) == 0, "R5 count sweep");
            pulse_done();
        end
        check(status[1] == 1'b0, "R9 done clears latch", status[1], 0);

        // R6 / R7: BP x sector sweep
        for (int b = 0; b < 8; b++) begin
            load_sr(1'b0, b[2:0]);
            check(status == {3'b000, b[2:0], 2'b00}, "R8 status load", status, {b[2:0], 2'b00});
            for (int s = 0; s < 8; s++) begin
                logic [18:0] a;
                a = {s[2:0], 16'h1234};
                send(8'h06, '0, 16'd8, '0);
                send(8'h02, a, 16'd32, '0);
                expect_verdict(!sect_prot(b, s), "R6 program map");
                check(status[1] == 1'b1, "R6 latch unchanged", status[1], 1);
                send(8'hD8, a, 16'd32, '0);
                expect_verdict(!sect_prot(b, s), "R6 erase map");
                pulse_done();
            end
            send(8'h06, '0, 16'd8, '0);
            send(8'hC7, '0, 16'd8, '0);
            expect_verdict(b == 0, "R7 bulk erase");
            pulse_done();
        end

        // R8: hardware lock
        load_sr(1'b1, 3'd3);
        check(status == 8'h8C, "R8 lock set", status, 8'h8C);
        wp_n = 1'b0;
        send(8'h06, '0, 16'd8, '0);
        send(8'h01, '0, 16'd16, 8'h00);
        expect_verdict(1'b0, "R8 locked write");
        check(status == 8'h8E, "R8 bits held", status, 8'h8E);
        wp_n = 1'b1;
        send(8'h01, '0, 16'd16, 8'h00);
        expect_verdict(1'b1, "R8 unlocked write");
        check(status == 8'h02, "R8 bits written", status, 8'h02);

        // R9: same-cycle precedence
        @(negedge clk); op_done = 1'b1;
        send(8'h06, '0, 16'd8, '0);
        op_done = 1'b0;
        check(status[1] == 1'b1, "R9 instruction wins", status[1], 1);

        // R10: deep power-down sweep
        send(8'hB9, '0, 16'd8, '0);
        expect_verdict(1'b1, "R10 enter sleep");
        for (int op = 0; op < 256; op++) begin
            if (op != 8'hAB) begin
                send(op[7:0], '0, 16'd8, 8'hFC);
                expect_verdict(1'b0, "R10 ignored in sleep");
            end
        end
        check(status == 8'h02, "R10 status untouched", status, 8'h02);
        send(8'hAB, '0, 16'd8, '0);
        expect_verdict(1'b1, "R10 release");
        send(8'h04, '0, 16'd8, '0);
        expect_verdict(1'b1, "R10 active again");
        check(status == 8'h00, "R10 latch cleared after wake", status, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule